// File: doc/BRIEF.md
# BCD Timekeeping Register Clock

This block is a calendar clock that counts seconds, minutes, hours, weekday, date, month and a two-digit year. It is advanced by a single-cycle pulse on a one-second tick input. It handles month lengths, leap years and the wrap from year 99 to year 00. Software sees eight byte registers on a plain synchronous bus. Each time field reads back in BCD. Each field written from the bus is decoded as tens × 10 + units and kept only if it lies in that field's legal range.

A hold bit shares the seconds register with the seconds value. While the hold bit is set, ticks are ignored and the held time is kept intact. Clearing the bit lets counting continue from the held value, so software can set the clock consistently.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the clock reads 00:00:00 with weekday 1, date 1, month 1 and year 00. The hold bit and the century bit read 0, and the control register reads 0x90.
- R2: A tick with the hold bit clear, and no bus write to a time register in the same cycle, adds one to the seconds.
- R3: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date and the weekday. The weekday wraps from 7 to 1.
- R4: The date rolls to 1 and the month advances after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in February, or after day 29 when the year is a multiple of 4 (year 00 included).
- R5: At the end of day 31 of month 12 the month returns to 1, and the year advances, wrapping from 99 to 00.
- R6: Register 1 bit 7 is the hold bit and is stored on every write to register 1. While it is set, ticks leave all time fields unchanged. A read of register 1 returns the hold bit in bit 7 and the BCD seconds in bits 6:0.
- R7: Seconds (register 1) and minutes (register 2) decode bits 6:4 as tens and bits 3:0 as units, and accept 0 to 59. Hours (register 3) decode bits 5:4 as tens and accept 0 to 23. A non-BCD units digit still decodes arithmetically, so 0x1A is accepted as hour 20.
- R8: The date (register 5) decodes bits 5:4 as tens and accepts 1 to 31. The month (register 6) decodes bit 4 as tens and accepts 1 to 12. The year (register 7) decodes all eight bits as two digits and accepts 0 to 99.
- R9: A write whose decoded value is out of range leaves the time unchanged and raises no error. On register 1 the hold bit is still stored.
- R10: Register 4 takes the weekday from bits 2:0 without a range check and stores bit 6 as the century bit. A read returns the century in bit 6, the weekday in bits 2:0, and zero in the other bits.
- R11: A write of v to register 0 stores (v AND 0x5F) OR 0x90.
- R12: When a bus write to any of registers 1 to 7 meets a tick in the same cycle, the write is applied and that tick is dropped. A write to register 0 does not block the tick.
- R13: rdata_o shows the register addressed in a cycle with re_i high from the next cycle on, and it keeps that value until the next read. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| addr_i | input | 3 | Register select: 0 control, 1 seconds and hold, 2 minutes, 3 hours, 4 weekday and century, 5 date, 6 month, 7 year |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |

## Verification
The tick and a bus write can arrive in the same cycle. The bench forces this three ways: a tick with a minutes write, a tick with a control write, and a tick with a write that sets the hold bit. It then reads back the seconds to confirm that the time-register write consumed the tick and the control write did not. A read and a write to the same register are also issued together. The bench checks that the old value comes out, and that it stays on rdata_o until the next read. A behavioural model in the bench predicts rdata_o for every cycle, so the effect of each collision is also compared outside these directed checks.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_SEC   = 3'd1,
    REG_MIN   = 3'd2,
    REG_HOUR  = 3'd3,
    REG_WDAY  = 3'd4,
    REG_DATE  = 3'd5,
    REG_MONTH = 3'd6,
    REG_YEAR  = 3'd7
  } reg_sel_e;

  // time kept in binary, converted to BCD only on read
  typedef struct packed {
    logic [6:0] year;
    logic [3:0] month;
    logic [4:0] date;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_of(logic [6:0] v);
    logic [6:0] t;
    logic [6:0] u;
    t = v / 7'd10;
    u = v - t * 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] dec_of(logic [3:0] hi, logic [3:0] lo);
    return {4'd0, hi} * 8'd10 + {4'd0, lo};
  endfunction
endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_bcd_pkg::*;
(
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ok_o,
  output logic [6:0]        val_o
);
  logic [7:0] d;

  always_comb begin
    d    = '0;
    ok_o = 1'b1;
    case (sel_i)
      REG_SEC, REG_MIN: begin
        d    = dec_of({1'b0, wdata_i[6:4]}, wdata_i[3:0]);
        ok_o = d <= 8'd59;
      end
      REG_HOUR: begin
        d    = dec_of({2'b0, wdata_i[5:4]}, wdata_i[3:0]);
        ok_o = d <= 8'd23;
      end
      REG_DATE: begin
        d    = dec_of({2'b0, wdata_i[5:4]}, wdata_i[3:0]);
        ok_o = (d >= 8'd1) && (d <= 8'd31);
      end
      REG_MONTH: begin
        d    = dec_of({3'b0, wdata_i[4]}, wdata_i[3:0]);
        ok_o = (d >= 8'd1) && (d <= 8'd12);
      end
      REG_YEAR: begin
        d    = dec_of(wdata_i[7:4], wdata_i[3:0]);
        ok_o = d <= 8'd99;
      end
      REG_WDAY: d = {5'd0, wdata_i[2:0]};
      default:  d = '0;
    endcase
  end

  assign val_o = d[6:0];
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_bcd_pkg::*;
#(
  parameter int LEAP_MOD = 4
) (
  input  rtc_time_t cur_i,
  output rtc_time_t nxt_o
);
  logic [4:0] last_day;

  always_comb begin
    case (cur_i.month)
      4'd2:                     last_day = ((32'(cur_i.year) % LEAP_MOD) == 0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  last_day = 5'd30;
      default:                  last_day = 5'd31;
    endcase
  end

  always_comb begin
    nxt_o = cur_i;
    if (cur_i.sec < 6'd59) nxt_o.sec = cur_i.sec + 6'd1;
    else begin
      nxt_o.sec = '0;
      if (cur_i.min < 6'd59) nxt_o.min = cur_i.min + 6'd1;
      else begin
        nxt_o.min = '0;
        if (cur_i.hour < 5'd23) nxt_o.hour = cur_i.hour + 5'd1;
        else begin
          nxt_o.hour = '0;
          nxt_o.wday = (cur_i.wday >= 3'd7) ? 3'd1 : cur_i.wday + 3'd1;
          if (cur_i.date < last_day) nxt_o.date = cur_i.date + 5'd1;
          else begin
            nxt_o.date = 5'd1;
            if (cur_i.month < 4'd12) nxt_o.month = cur_i.month + 4'd1;
            else begin
              nxt_o.month = 4'd1;
              nxt_o.year  = (cur_i.year >= 7'd99) ? 7'd0 : cur_i.year + 7'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_bcd_pkg::*;
#(
  parameter logic [7:0] CTRL_SET = 8'h90,
  parameter logic [7:0] CTRL_CLR = 8'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e    sel;
  rtc_time_t   time_q, time_nxt;
  logic        stop_q, cent_q;
  logic [7:0]  ctrl_q, rdata_q, view;
  logic        wr_ok, time_wr, adv;
  logic [6:0]  wr_val;

  assign sel = reg_sel_e'(addr_i);

  rtc_wr_decode u_dec (.sel_i(sel), .wdata_i(wdata_i), .ok_o(wr_ok), .val_o(wr_val));
  rtc_cal_step  u_step (.cur_i(time_q), .nxt_o(time_nxt));

  // bus write to a time register takes the cycle; its tick is dropped
  assign time_wr = we_i && (sel != REG_CTRL);
  assign adv     = tick_i && !stop_q && !time_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '{year: 7'd0, month: 4'd1, date: 5'd1, wday: 3'd1,
                  hour: 5'd0, min: 6'd0, sec: 6'd0};
      stop_q <= 1'b0;
      cent_q <= 1'b0;
      ctrl_q <= CTRL_SET;
    end else if (we_i) begin
      case (sel)
        REG_CTRL:  ctrl_q <= (wdata_i & ~CTRL_CLR) | CTRL_SET;
        REG_SEC: begin
          stop_q <= wdata_i[7];
          if (wr_ok) time_q.sec <= wr_val[5:0];
        end
        REG_MIN:   if (wr_ok) time_q.min   <= wr_val[5:0];
        REG_HOUR:  if (wr_ok) time_q.hour  <= wr_val[4:0];
        REG_WDAY: begin
          time_q.wday <= wr_val[2:0];
          cent_q      <= wdata_i[6];
        end
        REG_DATE:  if (wr_ok) time_q.date  <= wr_val[4:0];
        REG_MONTH: if (wr_ok) time_q.month <= wr_val[3:0];
        REG_YEAR:  if (wr_ok) time_q.year  <= wr_val;
        default: ;
      endcase
      if (!time_wr && adv) time_q <= time_nxt;
    end else if (adv) begin
      time_q <= time_nxt;
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:  view = ctrl_q;
      REG_SEC:   view = {stop_q, 7'(bcd_of({1'b0, time_q.sec}))};
      REG_MIN:   view = bcd_of({1'b0, time_q.min});
      REG_HOUR:  view = bcd_of({2'b0, time_q.hour});
      REG_WDAY:  view = {1'b0, cent_q, 3'b000, time_q.wday};
      REG_DATE:  view = bcd_of({2'b0, time_q.date});
      REG_MONTH: view = bcd_of({3'b0, time_q.month});
      default:   view = bcd_of(time_q.year);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= view;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rtc_bcd_chk.sv
module rtc_bcd_chk
  import rtc_bcd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       we_i,
  input logic [2:0] addr_i,
  input logic       re_i,
  input logic [7:0] rdata_o,
  input rtc_time_t  time_q,
  input logic       stop_q,
  input logic [7:0] ctrl_q
);
  a_r2_tick_adds_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !stop_q && !we_i && (time_q.sec < 6'd59) |=> time_q.sec == $past(time_q.sec) + 6'd1);

  a_r3_sec_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !stop_q && !we_i && (time_q.sec == 6'd59) |=> time_q.sec == 6'd0);

  a_r6_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q && !we_i |=> $stable(time_q));

  a_r7_clock_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_q.sec <= 6'd59) && (time_q.min <= 6'd59) && (time_q.hour <= 5'd23));

  a_r8_calendar_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_q.date >= 5'd1) && (time_q.date <= 5'd31) && (time_q.month >= 4'd1) &&
    (time_q.month <= 4'd12) && (time_q.year <= 7'd99));

  a_r11_ctrl_forced_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);

  a_r12_write_beats_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && we_i && (addr_i == 3'd2) |=> time_q.sec == $past(time_q.sec));

  a_r13_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

bind rtc_bcd_core rtc_bcd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i), .addr_i(addr_i),
  .re_i(re_i), .rdata_o(rdata_o), .time_q(time_q), .stop_q(stop_q), .ctrl_q(ctrl_q)
);

// File: tb/sim_rtc_bcd_core.sv
module sim_rtc_bcd_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       re_i = 1'b0;
  logic [7:0] rdata_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rtc_bcd_core u0 (.clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
                   .we_i(we_i), .wdata_i(wdata_i), .re_i(re_i), .rdata_o(rdata_o));

  // behavioural reference model
  int m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y, m_stop, m_cent, m_ctrl, m_rd;

  function automatic int bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int m_view(int a);
    case (a)
      0: return m_ctrl;
      1: return (m_stop << 7) | bcd(m_s);
      2: return bcd(m_mi);
      3: return bcd(m_h);
      4: return (m_cent << 6) | m_wd;
      5: return bcd(m_d);
      6: return bcd(m_mo);
      default: return bcd(m_y);
    endcase
  endfunction

  task automatic m_reset();
    m_s = 0; m_mi = 0; m_h = 0; m_wd = 1; m_d = 1; m_mo = 1; m_y = 0;
    m_stop = 0; m_cent = 0; m_ctrl = 'h90; m_rd = 0;
  endtask

  task automatic m_tick();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_wd = (m_wd >= 7) ? 1 : m_wd + 1;
          m_d++;
          if (m_d > mdays(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic m_write(int a, int v);
    int t;
    case (a)
      0: m_ctrl = (v & 'h5F) | 'h90;
      1: begin t = ((v >> 4) & 7) * 10 + (v & 15); m_stop = (v >> 7) & 1; if (t <= 59) m_s = t; end
      2: begin t = ((v >> 4) & 7) * 10 + (v & 15); if (t <= 59) m_mi = t; end
      3: begin t = ((v >> 4) & 3) * 10 + (v & 15); if (t <= 23) m_h = t; end
      4: begin m_wd = v & 7; m_cent = (v >> 6) & 1; end
      5: begin t = ((v >> 4) & 3) * 10 + (v & 15); if (t >= 1 && t <= 31) m_d = t; end
      6: begin t = ((v >> 4) & 1) * 10 + (v & 15); if (t >= 1 && t <= 12) m_mo = t; end
      default: begin t = ((v >> 4) & 15) * 10 + (v & 15); if (t <= 99) m_y = t; end
    endcase
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      if (re_i) m_rd = m_view(int'(addr_i));
      if (we_i) begin
        m_write(int'(addr_i), int'(wdata_i));
        if (addr_i == 3'd0 && tick_i && m_stop == 0) m_tick();
      end else if (tick_i && m_stop == 0) m_tick();
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      total++;
      if (int'(rdata_o) != m_rd) begin
        bad++;
        $display("FAIL R13 model compare: actual=%02h expected=%02h", rdata_o, m_rd[7:0]);
      end
    end
  end

  task automatic cyc(bit w, int a, int d, bit r, bit t);
    we_i = w; addr_i = 3'(a); wdata_i = 8'(d); re_i = r; tick_i = t;
    @(negedge clk_i);
    we_i = 0; re_i = 0; tick_i = 0;
  endtask

  task automatic wr(int a, int d);
    cyc(1, a, d, 0, 0);
  endtask

  task automatic tick();
    cyc(0, 0, 0, 0, 1);
  endtask

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic rd(string tag, int a, int exp);
    cyc(0, a, 0, 1, 0);
    check(tag, int'(rdata_o), exp);
  endtask

  task automatic set_time(int y, int mo, int d, int h, int mi, int s);
    wr(7, y); wr(6, mo); wr(5, d); wr(3, h); wr(2, mi); wr(1, s);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset values
    rd("R1 ctrl", 0, 'h90); rd("R1 sec", 1, 'h00); rd("R1 min", 2, 'h00);
    rd("R1 hour", 3, 'h00); rd("R1 wday", 4, 'h01); rd("R1 date", 5, 'h01);
    rd("R1 month", 6, 'h01); rd("R1 year", 7, 'h00);
    // R2 single tick
    tick(); rd("R2 sec", 1, 'h01);
    // R3 carry chain and weekday wrap
    wr(1, 'h59); wr(2, 'h59); wr(3, 'h23); wr(4, 'h07); tick();
    rd("R3 sec", 1, 'h00); rd("R3 min", 2, 'h00); rd("R3 hour", 3, 'h00);
    rd("R3 wday", 4, 'h01); rd("R3 date", 5, 'h02);
    // R4 month lengths and leap years
    set_time('h24, 'h02, 'h28, 'h23, 'h59, 'h59); tick();
    rd("R4 leap 29", 5, 'h29); rd("R4 leap month", 6, 'h02);
    set_time('h24, 'h02, 'h29, 'h23, 'h59, 'h59); tick();
    rd("R4 leap end date", 5, 'h01); rd("R4 leap end month", 6, 'h03);
    set_time('h23, 'h02, 'h28, 'h23, 'h59, 'h59); tick();
    rd("R4 common date", 5, 'h01); rd("R4 common month", 6, 'h03);
    set_time('h23, 'h04, 'h30, 'h23, 'h59, 'h59); tick();
    rd("R4 april date", 5, 'h01); rd("R4 april month", 6, 'h05);
    // R5 year wrap
    set_time('h99, 'h12, 'h31, 'h23, 'h59, 'h59); tick();
    rd("R5 year", 7, 'h00); rd("R5 month", 6, 'h01); rd("R5 date", 5, 'h01);
    // R6 hold bit
    wr(1, 'h85); rd("R6 held read", 1, 'h85);
    tick(); tick(); tick();
    rd("R6 frozen", 1, 'h85); rd("R6 frozen min", 2, 'h00);
    wr(1, 'h05); tick(); rd("R6 resume", 1, 'h06);
    // R7 / R8 / R9 range checks
    wr(1, 'h60); rd("R9 sec reject", 1, 'h06);
    wr(2, 'h7A); rd("R7 min reject", 2, 'h00);
    wr(3, 'h24); rd("R7 hour reject", 3, 'h00);
    wr(3, 'h1A); rd("R7 hour non-bcd", 3, 'h20);
    wr(5, 'h00); rd("R8 date zero", 5, 'h01);
    wr(5, 'h32); rd("R8 date 32", 5, 'h01);
    wr(5, 'h31); rd("R8 date 31", 5, 'h31);
    wr(6, 'h13); rd("R8 month 13", 6, 'h01);
    wr(6, 'h00); rd("R8 month 0", 6, 'h01);
    wr(7, 'hA0); rd("R8 year A0", 7, 'h00);
    wr(7, 'h9F); rd("R8 year 9F", 7, 'h00);
    wr(7, 'h0F); rd("R8 year 0F", 7, 'h15);
    wr(1, 'hE0); rd("R9 hold kept on reject", 1, 'h86);
    wr(1, 'h06); rd("R9 hold cleared", 1, 'h06);
    // R10 weekday / century
    wr(4, 'hFF); rd("R10 wday full", 4, 'h47);
    wr(4, 'h02); rd("R10 wday plain", 4, 'h02);
    // R11 control
    wr(0, 'hFF); rd("R11 ctrl ff", 0, 'hDF);
    wr(0, 'h00); rd("R11 ctrl 00", 0, 'h90);
    // R12 write vs tick
    wr(1, 'h10);
    cyc(1, 2, 'h30, 0, 1);
    rd("R12 tick dropped", 1, 'h10); rd("R12 write kept", 2, 'h30);
    cyc(1, 0, 'h00, 0, 1);
    rd("R12 ctrl write lets tick", 1, 'h11);
    cyc(1, 1, 'h90, 0, 1);
    rd("R12 hold write drops tick", 1, 'h90);
    wr(1, 'h11);
    // R13 read/write collision and hold
    cyc(1, 1, 'h20, 1, 0);
    check("R13 old value", int'(rdata_o), 'h11);
    @(negedge clk_i);
    check("R13 held", int'(rdata_o), 'h11);
    rd("R13 new value", 1, 'h20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule